// File: doc/BRIEF.md
# Idle-Mode Clock Switching Sequencer

This block is the power-management sequencer of a small microcontroller. It decides which clock source feeds the CPU and which feeds the peripherals while the core idles, while it wakes, and while it returns to the primary oscillator. In the idle-on-internal-oscillator mode the CPU clock is gated. The peripherals keep running from the internal oscillator multiplexer, and the primary oscillator is switched off.

A wake event starts a short fixed delay. The CPU then resumes from the internal clock while the primary oscillator restarts. Once the primary source reports ready, and the optional PLL lock window has also run out, the sequencer moves the glitch-free mux back to the primary clock. It then clears the internal-stable flag and sets the primary-started flag. The oscillators and the mux are outside the block: they appear here only as enables and ready inputs. All delays are counted in cycles of an always-on reference clock, which is `clk`.

Top module: `idle_clk_seq`

## Requirements
- R1: After reset the block runs from the primary source. The outputs are then: cpu_clk_en=1, per_clk_en=1, use_int_clk=0, pri_osc_en=1, intosc_on=0, int_stable=0, pri_started=1.
- R2: Idle is entered on the edge after a cycle in which sleep_exec=1, idle_en=1 and src_sel[1]=1 all hold. src_sel[0] is ignored. A sleep strobe with idle_en=0 or src_sel[1]=0 leaves the CPU running from the primary source.
- R3: In idle the outputs are cpu_clk_en=0, per_clk_en=1, use_int_clk=1, pri_osc_en=0 and pri_started=0. When freq_sel is non-zero, intosc_on=1.
- R4: With freq_sel non-zero, int_stable rises SETTLE_CYC+2 edges after the sleep strobe is driven. It is still 0 one edge earlier, and the peripheral clock stays enabled throughout the wait.
- R5: With freq_sel=0 the internal output is off (intosc_on=0), the low-frequency RC runs (intrc_on=1) and int_stable stays 0.
- R6: After a wake event in idle, cpu_clk_en stays 0 for WAKE_CYC+1 edges. On the next edge the block enters internal run: cpu_clk_en=1, use_int_clk=1, pri_osc_en=1, per_clk_en=1.
- R7: In internal run with pll_used=0, pri_ready=1 starts a one-cycle handover on the next edge. During it cpu_clk_en=0, per_clk_en=0 and use_int_clk=0. On the edge after that the block is in primary run with int_stable=0 and pri_started=1.
- R8: With pll_used=1, pri_ready must stay high for PLL_CYC further edges before the handover. use_int_clk is still 1 after PLL_CYC edges and is 0 after PLL_CYC+1 edges.
- R9: A sleep strobe that meets R2 during internal run returns the block to idle. int_stable stays 1 if it was already set, and the primary oscillator and pri_started drop to 0.
- R10: A wake event that arrives while the internal source is still settling still leads to internal run. int_stable then rises at the time given in R4.
- R11: intrc_on is 1 whenever wdt_en or fscm_en is 1, in any state.
- R12: A wake event in primary run or in internal run has no effect on the clock enables or on the source select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_exec | input | 1 | One-cycle strobe: a sleep instruction executed |
| idle_en | input | 1 | Idle-on-sleep enable |
| src_sel | input | 2 | Clock source select; only bit 1 is decoded |
| freq_sel | input | 3 | Internal oscillator frequency select; 0 disables the internal output |
| wake_evt | input | 1 | Wake event |
| pri_ready | input | 1 | Primary oscillator start-up count finished |
| pll_used | input | 1 | Primary path uses the PLL, so a lock window is added |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| use_int_clk | output | 1 | Mux select: 1 = internal multiplexer, 0 = primary |
| pri_osc_en | output | 1 | Primary oscillator enable |
| intosc_on | output | 1 | Internal oscillator output enable |
| intrc_on | output | 1 | Low-frequency internal RC enable |
| int_stable | output | 1 | Internal-oscillator-stable status flag |
| pri_started | output | 1 | Primary start-up done status flag |

## Verification
The assertions check on every cycle that:
- the CPU clock stops with peripherals still running only after a qualifying sleep strobe;
- the primary oscillator is off only while the CPU is gated on the internal source;
- the handover pause lasts exactly one cycle;
- the start-up flag rises only out of that pause;
- the CPU resumes exactly WAKE_CYC+1 cycles after the wake wait begins.

The exact rise time of the stable flag, the PLL lock window, the frequency-select-zero case, the ignored wake events and the way the flag survives a return to idle only show up in the bench's scenarios.

// File: rtl/idle_clk_seq_pkg.sv
package idle_clk_seq_pkg;

    typedef enum logic [2:0] {
        PRI_RUN     = 3'd0,
        RC_IDLE     = 3'd1,
        WAKE_WAIT   = 3'd2,
        RC_RUN      = 3'd3,
        SWITCH_BACK = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       int_stable;
        logic       pri_started;
    } seq_regs_t;

endpackage

// File: rtl/idle_clk_seq_timer.sv
// Saturating run-length counter: done is high while run has been high
// for LIMIT consecutive edges; dropping run clears the count.
module idle_clk_seq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    generate
        if (LIMIT <= 0) begin : g_nodelay
            assign done = run;
        end else begin : g_count
            localparam int CW = $clog2(LIMIT + 1);
            localparam logic [CW-1:0] LIM = CW'(LIMIT);

            logic [CW-1:0] cnt_q;
            logic [CW-1:0] cnt_d;

            always_comb begin
                cnt_d = cnt_q;
                if (!run) begin
                    cnt_d = '0;
                end else if (cnt_q != LIM) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign done = run && (cnt_q == LIM);
        end
    endgenerate
endmodule

// File: rtl/idle_clk_seq_dec.sv
// Decodes the sequencer state into clock and oscillator enables.
module idle_clk_seq_dec
    import idle_clk_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic [2:0] freq_sel,
    input  logic       wdt_en,
    input  logic       fscm_en,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       use_int_clk,
    output logic       pri_osc_en,
    output logic       intosc_on,
    output logic       intrc_on
);
    logic on_internal;
    logic freq_nz;

    always_comb begin
        cpu_clk_en  = 1'b1;
        per_clk_en  = 1'b1;
        use_int_clk = 1'b0;
        pri_osc_en  = 1'b1;
        case (state)
            PRI_RUN: begin
                use_int_clk = 1'b0;
            end
            RC_IDLE: begin
                cpu_clk_en  = 1'b0;
                use_int_clk = 1'b1;
                pri_osc_en  = 1'b0;
            end
            WAKE_WAIT: begin
                cpu_clk_en  = 1'b0;
                use_int_clk = 1'b1;
            end
            RC_RUN: begin
                use_int_clk = 1'b1;
            end
            SWITCH_BACK: begin
                cpu_clk_en  = 1'b0;
                per_clk_en  = 1'b0;
                use_int_clk = 1'b0;
            end
            default: begin
                use_int_clk = 1'b0;
            end
        endcase
    end

    assign on_internal = (state != PRI_RUN);
    assign freq_nz     = |freq_sel;
    assign intosc_on   = on_internal && freq_nz;
    assign intrc_on    = wdt_en || fscm_en || (on_internal && !freq_nz);
endmodule

// File: rtl/idle_clk_seq.sv
module idle_clk_seq
    import idle_clk_seq_pkg::*;
#(
    parameter int WAKE_CYC   = 320,
    parameter int SETTLE_CYC = 32000,
    parameter int PLL_CYC    = 64000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_exec,
    input  logic       idle_en,
    input  logic [1:0] src_sel,
    input  logic [2:0] freq_sel,
    input  logic       wake_evt,
    input  logic       pri_ready,
    input  logic       pll_used,
    input  logic       wdt_en,
    input  logic       fscm_en,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       use_int_clk,
    output logic       pri_osc_en,
    output logic       intosc_on,
    output logic       intrc_on,
    output logic       int_stable,
    output logic       pri_started
);
    seq_regs_t regs_q;
    seq_regs_t regs_d;

    logic idle_req;
    logic wake_done;
    logic settle_done;
    logic pll_done;
    logic pll_run;
    logic pri_go;

    idle_clk_seq_dec u_dec (
        .state       (regs_q.state),
        .freq_sel    (freq_sel),
        .wdt_en      (wdt_en),
        .fscm_en     (fscm_en),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .use_int_clk (use_int_clk),
        .pri_osc_en  (pri_osc_en),
        .intosc_on   (intosc_on),
        .intrc_on    (intrc_on)
    );

    idle_clk_seq_timer #(.LIMIT(WAKE_CYC)) u_wake_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (regs_q.state == WAKE_WAIT),
        .done  (wake_done)
    );

    idle_clk_seq_timer #(.LIMIT(SETTLE_CYC)) u_settle_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (intosc_on),
        .done  (settle_done)
    );

    assign pll_run = (regs_q.state == RC_RUN) && pri_ready && pll_used;

    idle_clk_seq_timer #(.LIMIT(PLL_CYC)) u_pll_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pll_run),
        .done  (pll_done)
    );

    assign idle_req = sleep_exec && idle_en && src_sel[1];
    assign pri_go   = pri_ready && (!pll_used || pll_done);

    always_comb begin
        regs_d            = regs_q;
        regs_d.int_stable = intosc_on && settle_done;
        case (regs_q.state)
            PRI_RUN: begin
                if (idle_req) begin
                    regs_d.state       = RC_IDLE;
                    regs_d.pri_started = 1'b0;
                end
            end
            RC_IDLE: begin
                if (wake_evt) begin
                    regs_d.state = WAKE_WAIT;
                end
            end
            WAKE_WAIT: begin
                if (wake_done) begin
                    regs_d.state = RC_RUN;
                end
            end
            RC_RUN: begin
                if (idle_req) begin
                    regs_d.state       = RC_IDLE;
                    regs_d.pri_started = 1'b0;
                end else if (pri_go) begin
                    regs_d.state = SWITCH_BACK;
                end
            end
            SWITCH_BACK: begin
                regs_d.state       = PRI_RUN;
                regs_d.int_stable  = 1'b0;
                regs_d.pri_started = 1'b1;
            end
            default: begin
                regs_d.state = PRI_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state       <= PRI_RUN;
            regs_q.int_stable  <= 1'b0;
            regs_q.pri_started <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign int_stable  = regs_q.int_stable;
    assign pri_started = regs_q.pri_started;
endmodule

// File: rtl/idle_clk_seq_chk.sv
module idle_clk_seq_chk #(
    parameter int WAKE_CYC = 320
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_exec,
    input logic       idle_en,
    input logic [1:0] src_sel,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       use_int_clk,
    input logic       pri_osc_en,
    input logic       int_stable,
    input logic       pri_started
);
    logic wait_sig;
    int   wait_cnt_q;

    assign wait_sig = !cpu_clk_en && per_clk_en && use_int_clk && pri_osc_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt_q <= 0;
        end else if (wait_sig) begin
            wait_cnt_q <= wait_cnt_q + 1;
        end else begin
            wait_cnt_q <= 0;
        end
    end

    a_r2_idle_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_clk_en) && per_clk_en) |-> $past(sleep_exec && idle_en && src_sel[1]));

    a_r3_pri_off_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_osc_en |-> (use_int_clk && !cpu_clk_en && !pri_started));

    a_r4_stable_only_internal: assert property (@(posedge clk) disable iff (!rst_n)
        (int_stable && per_clk_en) |-> use_int_clk);

    a_r6_wake_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_clk_en) && use_int_clk) |-> (wait_cnt_q == WAKE_CYC + 1));

    a_r7_pause_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !per_clk_en |=> per_clk_en);

    a_r7_started_after_pause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_started) |-> (!use_int_clk && cpu_clk_en && $past(!per_clk_en)));
endmodule

bind idle_clk_seq idle_clk_seq_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_exec  (sleep_exec),
    .idle_en     (idle_en),
    .src_sel     (src_sel),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .use_int_clk (use_int_clk),
    .pri_osc_en  (pri_osc_en),
    .int_stable  (int_stable),
    .pri_started (pri_started)
);

// File: tb/idle_clk_seq_test.sv
`timescale 1ns/1ps
module idle_clk_seq_test;
    localparam int W = 8;
    localparam int S = 40;
    localparam int P = 20;

    localparam logic [7:0] M_CPU = 8'h80;
    localparam logic [7:0] M_PER = 8'h40;
    localparam logic [7:0] M_USE = 8'h20;
    localparam logic [7:0] M_PRI = 8'h10;
    localparam logic [7:0] M_IOS = 8'h08;
    localparam logic [7:0] M_IRC = 8'h04;
    localparam logic [7:0] M_ST  = 8'h02;
    localparam logic [7:0] M_STD = 8'h01;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, sleep_exec, idle_en, wake_evt, pri_ready, pll_used, wdt_en, fscm_en;
    logic [1:0] src_sel;
    logic [2:0] freq_sel;
    logic       cpu_clk_en, per_clk_en, use_int_clk, pri_osc_en;
    logic       intosc_on, intrc_on, int_stable, pri_started;

    idle_clk_seq #(.WAKE_CYC(W), .SETTLE_CYC(S), .PLL_CYC(P)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .idle_en(idle_en),
        .src_sel(src_sel), .freq_sel(freq_sel), .wake_evt(wake_evt),
        .pri_ready(pri_ready), .pll_used(pll_used), .wdt_en(wdt_en), .fscm_en(fscm_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .use_int_clk(use_int_clk),
        .pri_osc_en(pri_osc_en), .intosc_on(intosc_on), .intrc_on(intrc_on),
        .int_stable(int_stable), .pri_started(pri_started)
    );

    typedef struct {
        int         at;
        logic [7:0] mask;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares queued expectations against the outputs in the cycle they name.
    initial begin
        forever begin
            logic [7:0] obs;
            @(negedge clk);
            #1;
            obs = {cpu_clk_en, per_clk_en, use_int_clk, pri_osc_en,
                   intosc_on, intrc_on, int_stable, pri_started};
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].at == cyc) begin
                    n_checks++;
                    if ((obs & sbq[i].mask) !== (sbq[i].val & sbq[i].mask)) begin
                        n_fail++;
                        $display("FAIL %s cycle %0d: actual=%b expected=%b mask=%b",
                                 sbq[i].req, cyc, obs, sbq[i].val, sbq[i].mask);
                    end
                    sbq.delete(i);
                end
            end
        end
    end

    task automatic expect_at(int n, logic [7:0] m, logic [7:0] v, string r);
        exp_t e;
        e.at = cyc + n;
        e.mask = m;
        e.val = v;
        e.req = r;
        sbq.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks + 1, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sleep_exec = 1'b0; idle_en = 1'b0; wake_evt = 1'b0;
        pri_ready = 1'b0; pll_used = 1'b0; wdt_en = 1'b0; fscm_en = 1'b0;
        src_sel = 2'b00; freq_sel = 3'b000;
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(1, 8'hFF, 8'b1101_0001, "R1");
        tick(2);

        // R2: sleep without idle_en, then with src_sel[1]=0
        idle_en = 1'b0; src_sel = 2'b11; sleep_exec = 1'b1;
        expect_at(2, M_CPU | M_USE, M_CPU, "R2");
        tick(1); sleep_exec = 1'b0; tick(2);
        idle_en = 1'b1; src_sel = 2'b01; sleep_exec = 1'b1;
        expect_at(2, M_CPU | M_USE, M_CPU, "R2");
        tick(1); sleep_exec = 1'b0; tick(2);

        // R11: watchdog / monitor keep the RC on
        wdt_en = 1'b1;
        expect_at(0, M_IRC, M_IRC, "R11");
        tick(1); wdt_en = 1'b0; fscm_en = 1'b1;
        expect_at(0, M_IRC, M_IRC, "R11");
        tick(1); fscm_en = 1'b0;
        expect_at(0, M_IRC, 8'h00, "R11");
        tick(1);

        // R3 / R4: enter idle with non-zero frequency (src_sel[0]=0)
        src_sel = 2'b10; freq_sel = 3'b100; sleep_exec = 1'b1;
        expect_at(1, 8'hFB, 8'b0110_1000, "R3");
        expect_at(S + 1, M_ST | M_PER, M_PER, "R4");
        expect_at(S + 2, M_ST | M_PER, M_ST | M_PER, "R4");
        tick(1); sleep_exec = 1'b0; tick(S + 3);

        // R6: wake delay then internal run
        wake_evt = 1'b1;
        expect_at(W + 1, M_CPU | M_PER, M_PER, "R6");
        expect_at(W + 2, M_CPU | M_PER | M_USE | M_PRI, M_CPU | M_PER | M_USE | M_PRI, "R6");
        tick(1); wake_evt = 1'b0; tick(W + 3);

        // R12: wake in internal run ignored
        wake_evt = 1'b1;
        expect_at(2, M_CPU | M_USE, M_CPU | M_USE, "R12");
        tick(1); wake_evt = 1'b0; tick(2);

        // R9: back to idle from internal run, stable flag kept (src_sel[0]=1 ignored)
        src_sel = 2'b11; sleep_exec = 1'b1;
        expect_at(1, M_CPU | M_ST | M_PRI | M_STD, M_ST, "R9");
        expect_at(6, M_CPU | M_ST, M_ST, "R9");
        tick(1); sleep_exec = 1'b0; tick(6);
        wake_evt = 1'b1; tick(1); wake_evt = 1'b0; tick(W + 3);

        // R7: primary ready without PLL
        pll_used = 1'b0; pri_ready = 1'b1;
        expect_at(1, M_CPU | M_PER | M_USE | M_ST | M_STD, M_ST, "R7");
        expect_at(2, M_CPU | M_PER | M_USE | M_ST | M_STD | M_PRI | M_IOS,
                  M_CPU | M_PER | M_STD | M_PRI, "R7");
        tick(3);

        // R12: wake in primary run ignored
        wake_evt = 1'b1;
        expect_at(2, M_CPU | M_USE, M_CPU, "R12");
        tick(1); wake_evt = 1'b0; tick(2);

        // R5: frequency select zero
        freq_sel = 3'b000; pri_ready = 1'b0; sleep_exec = 1'b1;
        expect_at(1, M_IOS | M_IRC | M_ST | M_USE, M_IRC | M_USE, "R5");
        expect_at(S + 4, M_ST | M_IRC, M_IRC, "R5");
        tick(1); sleep_exec = 1'b0; tick(S + 4);
        wake_evt = 1'b1; tick(1); wake_evt = 1'b0; tick(W + 3);

        // R8: PLL lock window
        pll_used = 1'b1; pri_ready = 1'b1;
        expect_at(P, M_USE | M_CPU, M_USE | M_CPU, "R8");
        expect_at(P + 1, M_USE | M_PER, 8'h00, "R8");
        expect_at(P + 2, M_USE | M_STD | M_CPU, M_STD | M_CPU, "R8");
        tick(P + 4);

        // R10: wake during settling
        pll_used = 1'b0; pri_ready = 1'b0; freq_sel = 3'b001; src_sel = 2'b10;
        sleep_exec = 1'b1;
        expect_at(S + 2, M_ST, M_ST, "R10");
        tick(1); sleep_exec = 1'b0; tick(2);
        wake_evt = 1'b1;
        expect_at(W + 2, M_CPU | M_USE | M_ST, M_CPU | M_USE, "R10");
        tick(1); wake_evt = 1'b0; tick(S);
        expect_at(0, M_CPU | M_USE | M_ST, M_CPU | M_USE | M_ST, "R10");
        tick(1);
        pri_ready = 1'b1;
        tick(4);

        while (sbq.size() != 0) tick(1);
        tick(1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule